// File: doc/BRIEF.md
# Programmable LCD Timing Generator

This block produces the raster timing for a parallel LCD panel. It makes horizontal sync, vertical sync and data enable, and it reports the current pixel column and line. It also pulses once at the start of every frame. All geometry comes from three packed 32-bit timing words. Most of their fields store a value minus one. The active width is given in units of 16 pixels. Every counter step is qualified by a pixel clock enable, so the block runs on the system clock and follows a slower pixel rate.

Separate control inputs invert the sync and data-enable polarities. A further bit asks the panel interface to launch data on the opposite clock edge, for receivers that need a long setup time. Fetching pixels, formatting colour, powering the panel and dividing the clock are all left to neighbouring blocks.

Top module: `lcd_timing_gen`

## Requirements
- R1: While `en` is low, both counters are held at zero. From the cycle after `en` is sampled low, `hsync`, `vsync` and `de` sit at their inactive levels, which are equal to their invert inputs. `frame_start` and `launch_neg` are 0 at the same time.
- R2: The horizontal active width is 16*(htim[7:2]+1) pixels. `de` is at its active level only where the column is inside that width and the line is inside the active lines.
- R3: Each line runs in this order: active, then front porch of htim[23:16]+1 pixels, then sync of htim[15:8]+1 pixels, then back porch of htim[31:24]+1 pixels. `hsync` is active only during the sync part.
- R4: Each frame runs in this order: vtim[9:0]+1 active lines, then a front porch of vtim[23:16] lines, then vtim[15:10]+1 sync lines, then a back porch of vtim[31:24] lines. The two porches may be zero. `vsync` is active for the whole of the sync lines.
- R5: The column counter advances only in cycles where the block is running and `pix_ce` is high. The line counter advances only when a line completes. `pix_x` and `pix_y` show the counters.
- R6: `frame_start` is high for exactly one cycle. That cycle is the first in which the counters show column 0 of line 0 for a new frame. This covers the first frame after `en` rises and every frame that follows a wrap.
- R7: `inv_hs`, `inv_vs` and `inv_de` each invert one output. An invert bit of 1 makes its output active low.
- R8: `launch_neg` follows `inv_edge` while the block is running and is 0 otherwise.
- R9: The clocks-per-line field ctim[25:16] holds the number of data clocks minus one. `de` is inactive at any column greater than this field, even inside the active width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_ce | input | 1 | Pixel clock enable |
| en | input | 1 | Timing enable |
| htim | input | 32 | Horizontal timing word |
| vtim | input | 32 | Vertical timing word |
| ctim | input | 32 | Third timing word (clocks-per-line field at [25:16]) |
| inv_hs | input | 1 | Horizontal sync active low |
| inv_vs | input | 1 | Vertical sync active low |
| inv_de | input | 1 | Data enable active low |
| inv_edge | input | 1 | Request data launch on the opposite pixel clock edge |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_x | output | 11 | Current column |
| pix_y | output | 11 | Current line |
| frame_start | output | 1 | One-cycle frame start strobe |
| launch_neg | output | 1 | Edge select toward the panel interface |

## Verification
The counters, the running flag and `frame_start` are registers, so each of them shows the result of a clock edge in the cycle that follows it. Sync, data enable and `launch_neg` are decoded combinationally from those registers and from the live polarity inputs. They therefore change in the same cycle as the counters they are decoded from. The bench model updates its state at each rising edge from the inputs held since the previous falling edge. It compares every output a quarter period after that rising edge, while the inputs are still stable. The enable is released both between frames and in the middle of a frame, to exercise the one-cycle lag of the idle levels and the start-up pulse.

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_ce,
  input  logic          en,
  input  logic [31:0]   htim,
  input  logic [31:0]   vtim,
  input  logic [31:0]   ctim,
  input  logic          inv_hs,
  input  logic          inv_vs,
  input  logic          inv_de,
  input  logic          inv_edge,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [CW-1:0] pix_x,
  output logic [CW-1:0] pix_y,
  output logic          frame_start,
  output logic          launch_neg
);

  logic [CW-1:0] hcnt, vcnt;
  logic          run;

  wire unused_bits = &{1'b0, htim[1:0], ctim[31:26], ctim[15:0]};

  wire [CW-1:0] h_act  = ({{(CW-6){1'b0}}, htim[7:2]} + 1'b1) << 4;
  wire [CW-1:0] h_fpe  = h_act + {{(CW-8){1'b0}}, htim[23:16]} + 1'b1;
  wire [CW-1:0] h_sye  = h_fpe + {{(CW-8){1'b0}}, htim[15:8]} + 1'b1;
  wire [CW-1:0] h_tot  = h_sye + {{(CW-8){1'b0}}, htim[31:24]} + 1'b1;

  wire [CW-1:0] v_act  = {{(CW-10){1'b0}}, vtim[9:0]} + 1'b1;
  wire [CW-1:0] v_fpe  = v_act + {{(CW-8){1'b0}}, vtim[23:16]};
  wire [CW-1:0] v_sye  = v_fpe + {{(CW-6){1'b0}}, vtim[15:10]} + 1'b1;
  wire [CW-1:0] v_tot  = v_sye + {{(CW-8){1'b0}}, vtim[31:24]};

  wire [CW-1:0] cpl    = {{(CW-10){1'b0}}, ctim[25:16]};

  wire step   = run & pix_ce;
  wire h_last = hcnt >= h_tot - 1'b1;
  wire v_last = vcnt >= v_tot - 1'b1;
  wire wrap   = step & h_last & v_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt        <= '0;
      vcnt        <= '0;
      run         <= 1'b0;
      frame_start <= 1'b0;
    end else if (!en) begin
      hcnt        <= '0;
      vcnt        <= '0;
      run         <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      run         <= 1'b1;
      frame_start <= ~run | wrap;
      if (step) begin
        if (h_last) begin
          hcnt <= '0;
          vcnt <= v_last ? '0 : vcnt + 1'b1;
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end

  wire hs_on = run & (hcnt >= h_fpe) & (hcnt < h_sye);
  wire vs_on = run & (vcnt >= v_fpe) & (vcnt < v_sye);
  wire de_on = run & (hcnt < h_act) & (hcnt <= cpl) & (vcnt < v_act);

  assign hsync      = hs_on ^ inv_hs;
  assign vsync      = vs_on ^ inv_vs;
  assign de         = de_on ^ inv_de;
  assign pix_x      = hcnt;
  assign pix_y      = vcnt;
  assign launch_neg = run & inv_edge;

  a_r1_held_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pix_x == '0 && pix_y == '0 && !frame_start));

  a_r5_hold_no_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !pix_ce) |=> $stable(pix_x));

  a_r5_line_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pix_y) |-> pix_x == '0);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  a_r6_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (pix_x == '0 && pix_y == '0));

  a_r8_edge_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !launch_neg);

endmodule

// File: tb/lcd_timing_gen_test.sv
module lcd_timing_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_ce = 1'b0, en = 1'b0;
  logic [31:0] htim = '0, vtim = '0, ctim = '0;
  logic inv_hs = 1'b0, inv_vs = 1'b0, inv_de = 1'b0, inv_edge = 1'b0;
  logic hsync, vsync, de, frame_start, launch_neg;
  logic [10:0] pix_x, pix_y;

  always #10 clk = ~clk;

  lcd_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .en(en),
    .htim(htim), .vtim(vtim), .ctim(ctim),
    .inv_hs(inv_hs), .inv_vs(inv_vs), .inv_de(inv_de), .inv_edge(inv_edge),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y),
    .frame_start(frame_start), .launch_neg(launch_neg)
  );

  int aw, hf, hw, hb, al, vf, vw, vb, cplim;
  int mx = 0, my = 0, mrun = 0, mfs = 0;
  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;
  bit rnd_ce = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic setcfg(int w16, int f, int s, int b, int l, int vfp, int vsw, int vbp, int cp);
    aw = 16 * w16; hf = f; hw = s; hb = b; al = l; vf = vfp; vw = vsw; vb = vbp; cplim = cp;
    htim = ((b - 1) << 24) | ((f - 1) << 16) | ((s - 1) << 8) | ((w16 - 1) << 2);
    vtim = (vbp << 24) | (vfp << 16) | ((vsw - 1) << 10) | (l - 1);
    ctim = (cp - 1) << 16;
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at x=%0d y=%0d", tag, act, exp, mx, my);
    end
  endtask

  always @(posedge clk) begin
    int ht, vt, xs, ys;
    bit hon, von, don;
    string t;
    ht = aw + hf + hw + hb;
    vt = al + vf + vw + vb;
    if (!rst_n || !en) begin
      mx = 0; my = 0; mrun = 0; mfs = 0;
    end else begin
      mfs = (mrun == 0) || (pix_ce && mx == ht - 1 && my == vt - 1);
      if (mrun != 0 && pix_ce) begin
        if (mx == ht - 1) begin
          mx = 0;
          my = (my == vt - 1) ? 0 : my + 1;
        end else mx = mx + 1;
      end
      mrun = 1;
    end
    #5;
    if (!done) begin
      xs = mx; ys = my;
      hon = mrun != 0 && xs >= aw + hf && xs < aw + hf + hw;
      von = mrun != 0 && ys >= al + vf && ys < al + vf + vw;
      don = mrun != 0 && xs < aw && xs < cplim && ys < al;
      t = (mrun == 0) ? "R1" : ((inv_hs | inv_vs | inv_de) ? "R7" : "R3");
      chk(t, hsync, hon ^ inv_hs);
      t = (mrun == 0) ? "R1" : ((inv_hs | inv_vs | inv_de) ? "R7" : "R4");
      chk(t, vsync, von ^ inv_vs);
      t = (mrun == 0) ? "R1" : ((xs >= cplim && xs < aw) ? "R9" : "R2");
      chk(t, de, don ^ inv_de);
      chk("R5", pix_x, xs);
      chk("R5", pix_y, ys);
      chk("R6", frame_start, mfs);
      chk("R8", launch_neg, (mrun != 0) && inv_edge);
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run_cycles(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_ce = rnd_ce ? lfsr[0] : 1'b1;
    end
  endtask

  initial begin
    setcfg(1, 2, 3, 1, 4, 1, 2, 0, 16);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run_cycles(5);
    en = 1'b1;
    run_cycles(330);
    en = 1'b0;
    run_cycles(4);
    setcfg(2, 1, 1, 2, 2, 0, 1, 2, 21);
    inv_hs = 1'b1; inv_vs = 1'b1; inv_de = 1'b1; inv_edge = 1'b1;
    rnd_ce = 1;
    run_cycles(3);
    en = 1'b1;
    run_cycles(1200);
    en = 1'b0;
    run_cycles(3);
    en = 1'b1;
    inv_hs = 1'b0; inv_de = 1'b0;
    run_cycles(400);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule